// File: doc/BRIEF.md
# Command-Decoded Add/Shift Execution Unit

This unit runs one arithmetic or shift operation per start pulse. A caller presents a 4-bit command code and two unsigned operands in the cycle that `start` is high. Exactly one clock later, the unit raises `done` for a single cycle. In that same cycle it presents a 2-bit response code and the result word. The unit supports unsigned add, unsigned subtract, logical shift left and logical shift right. The shift distance comes from the low bits of the second operand. Add carry-out and subtract borrow are not wrapped silently: each returns an error response with a zeroed result.

The command map has gaps. Only codes 1 (add), 2 (subtract), 5 (shift left) and 6 (shift right) execute. Code 0 is a no-op and produces no response. Every other code is rejected with the error response.

The data path has no back-pressure and no valid/ready pair. The unit takes a new start in any cycle, including the cycle in which it reports an earlier result. The result is a one-cycle pulse, so the consumer must take it in the cycle it appears. Capturing the operands and arbitrating between callers are the job of the logic around this unit.

Top module: `au_exec_unit`

## Requirements
- R1: Command 1 returns response 1 with result op1 + op2 when the 33-bit sum has no carry out of bit 31.
- R2: Command 1 whose sum carries out of bit 31 returns response 2 with result 0.
- R3: Command 2 with op1 >= op2 returns response 1 with result op1 - op2 (0 when the operands are equal).
- R4: Command 2 with op2 > op1 returns response 2 with result 0.
- R5: Command 5 returns response 1 with op1 shifted left by op2[4:0] places, filling with zeros; op2 bits 31..5 have no effect.
- R6: Command 6 returns response 1 with op1 shifted right logically by op2[4:0] places, filling with zeros; op2 bits 31..5 have no effect.
- R7: Any command code in 3, 4 or 7 to 15 returns response 2 with result 0.
- R8: Command 0 given with start produces no done pulse, and resp and result stay 0.
- R9: done rises in the cycle after the clock edge that samples start. It lasts one cycle unless start is high again at that edge. Whenever done is low, resp and result are 0.
- R10: While rst_n is low, and in the first cycle after it, done, resp and result are 0.
- R11: Response code 3 (internal fault) is driven only if the command decode selects more than one operation or none at all; a valid stream never yields it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch one operation this cycle |
| cmd | input | 4 | Command code, sampled with start |
| op1 | input | 32 | First operand |
| op2 | input | 32 | Second operand; low 5 bits give the shift distance |
| done | output | 1 | One-cycle pulse carrying a response |
| resp | output | 2 | 0 none, 1 success, 2 invalid or carry/borrow, 3 internal fault |
| result | output | 32 | Result word, valid while done is high |

## Verification
Every response is due one rising edge after the edge that samples start, and falls away one edge later unless another start follows. The bench drives each command on a falling edge. It samples done, resp and result on the next falling edge, which lies half a period after the registering edge. One falling edge after that, it checks that the pulse has ended. The no-op and the back-to-back cases use the same two sample points: one to show that no pulse appears, and one to show that adjacent pulses each carry their own result.

// File: rtl/au_pkg.sv
package au_pkg;
  localparam int CMD_W = 4;

  localparam logic [CMD_W-1:0] C_NOP = 4'd0;
  localparam logic [CMD_W-1:0] C_ADD = 4'd1;
  localparam logic [CMD_W-1:0] C_SUB = 4'd2;
  localparam logic [CMD_W-1:0] C_SHL = 4'd5;
  localparam logic [CMD_W-1:0] C_SHR = 4'd6;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'd0,
    RSP_OK    = 2'd1,
    RSP_ERR   = 2'd2,
    RSP_FAULT = 2'd3
  } rsp_e;

  typedef struct packed {
    logic add;
    logic sub;
    logic shl;
    logic shr;
    logic bad;
  } sel_t;
endpackage

// File: rtl/au_decode.sv
module au_decode
  import au_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output logic             is_nop,
  output sel_t             sel
);
  always_comb begin
    sel    = '0;
    is_nop = 1'b0;
    unique case (cmd)
      C_NOP:   is_nop  = 1'b1;
      C_ADD:   sel.add = 1'b1;
      C_SUB:   sel.sub = 1'b1;
      C_SHL:   sel.shl = 1'b1;
      C_SHR:   sel.shr = 1'b1;
      default: sel.bad = 1'b1;
    endcase
  end

  // R11: a code is either the no-op or exactly one class
  always_comb begin
    a_r11_decode_onehot: assert (is_nop ? (sel == '0) : $onehot(sel));
  end
endmodule

// File: rtl/au_arith.sv
module au_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic              carry,
  output logic [DATA_W-1:0] diff,
  output logic              borrow
);
  logic [DATA_W:0] sum_w;
  logic [DATA_W:0] diff_w;

  always_comb begin
    sum_w  = {1'b0, a} + {1'b0, b};
    diff_w = {1'b0, a} - {1'b0, b};
  end

  assign sum    = sum_w[DATA_W-1:0];
  assign carry  = sum_w[DATA_W];
  assign diff   = diff_w[DATA_W-1:0];
  assign borrow = diff_w[DATA_W];

  // R2: a carry shows as a wrapped sum smaller than the first operand
  always_comb begin
    a_r2_carry_wrap: assert (carry == (sum < a));
  end
  // R4: without a borrow the difference cannot exceed the minuend
  always_comb begin
    a_r4_borrow_bound: assert (borrow || (diff <= a));
  end
endmodule

// File: rtl/au_shift.sv
module au_shift #(
  parameter int DATA_W = 32,
  parameter bit LEFT   = 1'b1,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [AMT_W-1:0]  amt,
  output logic [DATA_W-1:0] dout
);
  logic [AMT_W:0][DATA_W-1:0] stg;

  assign stg[0] = din;

  for (genvar i = 0; i < AMT_W; i++) begin : g_stage
    if (LEFT) begin : g_l
      assign stg[i+1] = amt[i] ? (stg[i] << (2**i)) : stg[i];
    end else begin : g_r
      assign stg[i+1] = amt[i] ? (stg[i] >> (2**i)) : stg[i];
    end
  end

  assign dout = stg[AMT_W];

  // R5/R6: a zero distance passes the operand unchanged
  always_comb begin
    a_r5_zero_dist: assert ((amt != '0) || (dout == din));
  end
endmodule

// File: rtl/au_exec_unit.sv
module au_exec_unit
  import au_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cmd,
  input  logic [DATA_W-1:0] op1,
  input  logic [DATA_W-1:0] op2,
  output logic              done,
  output logic [1:0]        resp,
  output logic [DATA_W-1:0] result
);
  logic              is_nop;
  sel_t              sel;
  logic [DATA_W-1:0] sum, diff, shl_v, shr_v;
  logic              carry, borrow;

  au_decode u_dec (.cmd(cmd), .is_nop(is_nop), .sel(sel));

  au_arith #(.DATA_W(DATA_W)) u_ar (
    .a(op1), .b(op2), .sum(sum), .carry(carry), .diff(diff), .borrow(borrow)
  );

  au_shift #(.DATA_W(DATA_W), .LEFT(1'b1)) u_shl (
    .din(op1), .amt(op2[AMT_W-1:0]), .dout(shl_v)
  );
  au_shift #(.DATA_W(DATA_W), .LEFT(1'b0)) u_shr (
    .din(op1), .amt(op2[AMT_W-1:0]), .dout(shr_v)
  );

  rsp_e              nxt_rsp;
  logic [DATA_W-1:0] nxt_res;

  always_comb begin
    nxt_rsp = RSP_OK;
    nxt_res = '0;
    if ($countones(sel) != 1) begin
      nxt_rsp = RSP_FAULT;
    end else if (sel.bad) begin
      nxt_rsp = RSP_ERR;
    end else if (sel.add) begin
      if (carry) nxt_rsp = RSP_ERR;
      else       nxt_res = sum;
    end else if (sel.sub) begin
      if (borrow) nxt_rsp = RSP_ERR;
      else        nxt_res = diff;
    end else if (sel.shl) begin
      nxt_res = shl_v;
    end else begin
      nxt_res = shr_v;
    end
  end

  logic launch;
  assign launch = start && !is_nop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done   <= 1'b0;
      resp   <= RSP_NONE;
      result <= '0;
    end else begin
      done   <= launch;
      resp   <= launch ? nxt_rsp : RSP_NONE;
      result <= launch ? nxt_res : '0;
    end
  end

  // R9: a non-no-op start yields done one edge later
  a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rst_n && cmd != C_NOP) |=> done);
  // R8: the no-op never raises done
  a_r8_nop_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rst_n && cmd == C_NOP) |=> !done);
  // R9: outputs idle when no response
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (resp == RSP_NONE && result == '0));
  // R2/R4/R7: error responses carry a zero word
  a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (done && resp == RSP_ERR) |-> result == '0);
  // R11: legal stream never reports an internal fault
  a_r11_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> resp != RSP_FAULT);
  // R1: a successful add returns the sum of the sampled operands
  a_r1_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rst_n && cmd == C_ADD && !carry) |=>
      (resp == RSP_OK && result == $past(op1) + $past(op2)));
endmodule

// File: tb/au_exec_unit_tb_top.sv
module au_exec_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  cmd;
  logic [31:0] op1, op2;
  logic        done;
  logic [1:0]  resp;
  logic [31:0] result;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  au_exec_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd),
    .op1(op1), .op2(op2), .done(done), .resp(resp), .result(result)
  );

  task automatic chk(input string req, input logic d, input logic [1:0] r,
                     input logic [31:0] v);
    n_chk++;
    if (done !== d || resp !== r || result !== v) begin
      n_fail++;
      $display("FAIL %s: got done=%0b resp=%0d result=%h, want done=%0b resp=%0d result=%h",
               req, done, resp, result, d, r, v);
    end
  endtask

  // drive on falling edge, sample next falling edge, then check pulse ended
  task automatic run_op(input string req, input logic [3:0] c, input logic [31:0] a,
                        input logic [31:0] b, input logic d, input logic [1:0] r,
                        input logic [31:0] v);
    @(negedge clk);
    start = 1'b1; cmd = c; op1 = a; op2 = b;
    @(negedge clk);
    start = 1'b0; cmd = 4'd0; op1 = '0; op2 = '0;
    chk(req, d, r, v);
    @(negedge clk);
    chk({req, " end"}, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; cmd = '0; op1 = '0; op2 = '0;
    repeat (3) @(negedge clk);
    chk("R10 in reset", 1'b0, 2'd0, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 after reset", 1'b0, 2'd0, 32'd0);
  endtask

  task automatic t_add();
    run_op("R1 add small", 4'd1, 32'd7, 32'd9, 1'b1, 2'd1, 32'd16);
    run_op("R1 add edge", 4'd1, 32'hFFFF_FFFE, 32'd1, 1'b1, 2'd1, 32'hFFFF_FFFF);
    run_op("R2 add carry", 4'd1, 32'hFFFF_FFFF, 32'd1, 1'b1, 2'd2, 32'd0);
    run_op("R2 add big carry", 4'd1, 32'h8000_0000, 32'h8000_0000, 1'b1, 2'd2, 32'd0);
  endtask

  task automatic t_sub();
    run_op("R3 sub", 4'd2, 32'd100, 32'd58, 1'b1, 2'd1, 32'd42);
    run_op("R3 sub equal", 4'd2, 32'h1234_5678, 32'h1234_5678, 1'b1, 2'd1, 32'd0);
    run_op("R4 sub borrow", 4'd2, 32'd3, 32'd4, 1'b1, 2'd2, 32'd0);
    run_op("R4 sub zero minuend", 4'd2, 32'd0, 32'hFFFF_FFFF, 1'b1, 2'd2, 32'd0);
  endtask

  task automatic t_shift();
    run_op("R5 shl 4", 4'd5, 32'h0000_00F1, 32'd4, 1'b1, 2'd1, 32'h0000_0F10);
    run_op("R5 shl 31", 4'd5, 32'h0000_0003, 32'd31, 1'b1, 2'd1, 32'h8000_0000);
    run_op("R5 shl high bits ignored", 4'd5, 32'hA5A5_A5A5, 32'hFFFF_FFE0, 1'b1, 2'd1, 32'hA5A5_A5A5);
    run_op("R6 shr 8", 4'd6, 32'hF000_00FF, 32'd8, 1'b1, 2'd1, 32'h00F0_0000);
    run_op("R6 shr 31", 4'd6, 32'hFFFF_FFFF, 32'd31, 1'b1, 2'd1, 32'h0000_0001);
    run_op("R6 shr high bits ignored", 4'd6, 32'h8000_0000, 32'h0000_0023, 1'b1, 2'd1, 32'h1000_0000);
  endtask

  task automatic t_invalid();
    for (int c = 3; c < 16; c++) begin
      if (c == 5 || c == 6) continue;
      run_op($sformatf("R7 bad code %0d", c), 4'(c), 32'd5, 32'd6, 1'b1, 2'd2, 32'd0);
    end
  endtask

  task automatic t_nop();
    run_op("R8 nop", 4'd0, 32'hDEAD_BEEF, 32'd1, 1'b0, 2'd0, 32'd0);
  endtask

  task automatic t_back2back();
    @(negedge clk);
    start = 1'b1; cmd = 4'd1; op1 = 32'd1; op2 = 32'd2;
    @(negedge clk);
    chk("R9 first of pair", 1'b1, 2'd1, 32'd3);
    cmd = 4'd6; op1 = 32'h100; op2 = 32'd4;
    @(negedge clk);
    start = 1'b0; cmd = '0; op1 = '0; op2 = '0;
    chk("R9 second of pair", 1'b1, 2'd1, 32'h10);
    @(negedge clk);
    chk("R9 pair ended", 1'b0, 2'd0, 32'd0);
  endtask

  initial begin
    t_reset();
    t_add();
    t_sub();
    t_shift();
    t_invalid();
    t_nop();
    t_back2back();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got running, want finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule